// File: doc/BRIEF.md
# Per-Scanline Sprite Evaluator

This block decides, for one video line at a time, which hardware sprites appear on that line. It keeps a small attribute store of 32 sprite entries. Each entry is four bytes, and the store is loaded one byte at a time through a simple write port. A start pulse launches a walk of the entries in ascending index order, one entry per clock. Every entry whose vertical span covers the requested line is copied into one of four output slots. The copy holds the entry index, the horizontal position after the early-clock shift, the address of the pattern row to fetch and the colour.

The walk stops early in two cases: it meets the terminator Y code, or a fifth covering sprite turns up. In the second case an overflow flag is raised and the index of that fifth sprite is kept. A one-cycle done pulse tells the downstream pattern fetcher and the status logic that the slots and flags are ready. The results stay unchanged until the next start. Pattern fetching, pixel shifting and collision detection are handled elsewhere.

Top module: `sprite_line_eval`

## Requirements
- R1: After reset, done_o, ovf_o, fifth_o and slot_vld_o are all 0.
- R2: Entry n occupies byte addresses 4n..4n+3 in this order: Y, X, pattern, attribute. A sprite covers line L when (L - (Y+1)) mod 256 is less than its height. The height is 8 lines, or 16 when big_i is 1. So Y=0xFF starts on line 0 and Y=0x00 starts on line 1.
- R3: With mag_i set, the height is doubled (16 or 32), and the row inside the pattern is (L - (Y+1)) shifted right by one.
- R4: An entry with Y=0xD0 ends the walk. That entry and all later entries are never selected, and fifth_o reports the index of the terminating entry when no overflow occurred.
- R5: The slot X is a 9-bit two's complement value. It equals X when attribute bit 7 is 0, and X-32 when attribute bit 7 is 1.
- R6: The slot row address is 11 bits. In 8x8 mode it is {pattern[7:0], row[2:0]}. In 16x16 mode it is {pattern[7:2], 1'b0, row[3:0]}, which addresses the left column of quadrants: upper-left, then lower-left.
- R7: The slot colour is attribute bits 3:0.
- R8: At most four slots are filled, in ascending entry order starting at slot 0, so slot_vld_o is one of 0000, 0001, 0011, 0111 or 1111. Slot i uses bits [i*5 +: 5] of slot_idx_o, [i*9 +: 9] of slot_x_o, [i*11 +: 11] of slot_addr_o and [i*4 +: 4] of slot_color_o.
- R9: On the fifth covering entry, ovf_o is set, fifth_o takes that entry's index and the walk ends, so later covering entries change nothing. A new start clears ovf_o and all slots.
- R10: When the walk reaches entry 31 without a terminator or an overflow, fifth_o reports 31.
- R11: done_o is a single-cycle pulse. It rises no more than 32 clocks after the edge that samples start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Attribute byte write strobe |
| wr_addr_i | input | 7 | Attribute byte address (entry*4 + byte) |
| wr_data_i | input | 8 | Attribute byte value |
| line_i | input | 8 | Line to evaluate, sampled during the walk |
| start_i | input | 1 | Begin a walk (restarts if busy) |
| big_i | input | 1 | 1 selects 16x16 sprites |
| mag_i | input | 1 | 1 selects doubled sprites |
| done_o | output | 1 | One-cycle completion pulse |
| slot_vld_o | output | 4 | Slot occupied flags |
| slot_idx_o | output | 20 | Entry index per slot |
| slot_x_o | output | 36 | Adjusted X per slot |
| slot_addr_o | output | 44 | Pattern row address per slot |
| slot_color_o | output | 16 | Colour per slot |
| ovf_o | output | 1 | More than four sprites cover the line |
| fifth_o | output | 5 | Fifth-sprite index or last examined entry |

## Verification
The terminator test and the slot-full test can fall on the same entry, and so can the last-entry test and the slot-full test. The bench builds tables in which the fifth covering sprite is followed by further covering sprites and a late terminator. It also builds a full 32-entry table in which entry 31 itself covers the line, so the final-entry exit and a slot write happen in the same cycle. A scoreboard model computed from the requirements judges the slots, the overflow flag and the reported index. The model shows whether the walk took the correct exit, and the bench also checks that done rose within the allowed window.

// File: rtl/sprite_eval_pkg.sv
package sprite_eval_pkg;

    localparam int BYTE_W    = 8;
    localparam int XPOS_W    = 9;
    localparam int ROWADDR_W = 11;
    localparam int COLOR_W   = 4;
    localparam logic [BYTE_W-1:0] END_Y = 8'hD0;
    localparam logic [XPOS_W-1:0] EARLY_SHIFT = 9'd32;

    typedef struct packed {
        logic [XPOS_W-1:0]    xpos;
        logic [ROWADDR_W-1:0] addr;
        logic [COLOR_W-1:0]   color;
    } slot_t;

endpackage

// File: rtl/sprite_attr_ram.sv
module sprite_attr_ram #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int ADDR_W = $clog2(ENTRIES * 4)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [7:0]        rd_y,
    output logic [7:0]        rd_x,
    output logic [7:0]        rd_pat,
    output logic [7:0]        rd_attr
);
    logic [7:0] mem [ENTRIES*4];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_y    = mem[{rd_idx, 2'd0}];
    assign rd_x    = mem[{rd_idx, 2'd1}];
    assign rd_pat  = mem[{rd_idx, 2'd2}];
    assign rd_attr = mem[{rd_idx, 2'd3}];
endmodule

// File: rtl/sprite_hit_calc.sv
module sprite_hit_calc
    import sprite_eval_pkg::*;
(
    input  logic [7:0] line,
    input  logic [7:0] ypos,
    input  logic [7:0] xpos,
    input  logic [7:0] pat,
    input  logic [7:0] attr,
    input  logic       big,
    input  logic       mag,
    output logic       hit,
    output slot_t      info
);
    logic [7:0] diff;
    logic [5:0] height;
    logic [3:0] row;

    always_comb begin
        // Y is stored one line early: the sprite starts on line Y+1
        diff   = line - (ypos + 8'd1);
        height = big ? 6'd16 : 6'd8;
        if (mag) begin
            height = {height[4:0], 1'b0};
        end
        hit = diff < {2'b00, height};
        row = mag ? diff[4:1] : diff[3:0];
        info.xpos  = {1'b0, xpos} - (attr[7] ? EARLY_SHIFT : '0);
        info.addr  = big ? {pat[7:2], 1'b0, row} : {pat, row[2:0]};
        info.color = attr[COLOR_W-1:0];
    end
endmodule

// File: rtl/sprite_line_eval.sv
module sprite_line_eval
    import sprite_eval_pkg::*;
#(
    parameter int NUM_SPR  = 32,
    parameter int SLOTS    = 4,
    localparam int IDX_W   = $clog2(NUM_SPR),
    localparam int ADDR_W  = $clog2(NUM_SPR * 4),
    localparam int SLOT_W  = $clog2(SLOTS),
    localparam int CNT_W   = $clog2(SLOTS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [ADDR_W-1:0]          wr_addr_i,
    input  logic [7:0]                 wr_data_i,
    input  logic [7:0]                 line_i,
    input  logic                       start_i,
    input  logic                       big_i,
    input  logic                       mag_i,
    output logic                       done_o,
    output logic [SLOTS-1:0]           slot_vld_o,
    output logic [SLOTS*IDX_W-1:0]     slot_idx_o,
    output logic [SLOTS*XPOS_W-1:0]    slot_x_o,
    output logic [SLOTS*ROWADDR_W-1:0] slot_addr_o,
    output logic [SLOTS*COLOR_W-1:0]   slot_color_o,
    output logic                       ovf_o,
    output logic [IDX_W-1:0]           fifth_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SPR - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(SLOTS);

    typedef struct packed {
        logic                        busy;
        logic                        done;
        logic [IDX_W-1:0]            idx;
        logic [CNT_W-1:0]            cnt;
        logic                        ovf;
        logic [IDX_W-1:0]            fifth;
        logic [SLOTS-1:0]            vld;
        logic [SLOTS-1:0][IDX_W-1:0] sidx;
        slot_t [SLOTS-1:0]           slot;
    } state_t;

    state_t q, d;

    logic [7:0] ent_y, ent_x, ent_pat, ent_attr;
    logic       ent_hit;
    slot_t      ent_info;

    sprite_attr_ram #(.ENTRIES(NUM_SPR)) u_ram (
        .clk     (clk),
        .wr_en   (wr_en_i),
        .wr_addr (wr_addr_i),
        .wr_data (wr_data_i),
        .rd_idx  (q.idx),
        .rd_y    (ent_y),
        .rd_x    (ent_x),
        .rd_pat  (ent_pat),
        .rd_attr (ent_attr)
    );

    sprite_hit_calc u_hit (
        .line (line_i),
        .ypos (ent_y),
        .xpos (ent_x),
        .pat  (ent_pat),
        .attr (ent_attr),
        .big  (big_i),
        .mag  (mag_i),
        .hit  (ent_hit),
        .info (ent_info)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start_i) begin
            d.busy  = 1'b1;
            d.idx   = '0;
            d.cnt   = '0;
            d.ovf   = 1'b0;
            d.fifth = '0;
            d.vld   = '0;
            d.sidx  = '0;
            d.slot  = '0;
        end else if (q.busy) begin
            if (ent_y == END_Y) begin
                d.busy  = 1'b0;
                d.done  = 1'b1;
                d.fifth = q.idx;
            end else if (ent_hit && (q.cnt == FULL_CNT)) begin
                d.busy  = 1'b0;
                d.done  = 1'b1;
                d.ovf   = 1'b1;
                d.fifth = q.idx;
            end else begin
                if (ent_hit) begin
                    d.vld[q.cnt[SLOT_W-1:0]]  = 1'b1;
                    d.sidx[q.cnt[SLOT_W-1:0]] = q.idx;
                    d.slot[q.cnt[SLOT_W-1:0]] = ent_info;
                    d.cnt = q.cnt + CNT_W'(1);
                end
                if (q.idx == LAST_IDX) begin
                    d.busy  = 1'b0;
                    d.done  = 1'b1;
                    d.fifth = q.idx;
                end else begin
                    d.idx = q.idx + IDX_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done_o     = q.done;
    assign ovf_o      = q.ovf;
    assign fifth_o    = q.fifth;
    assign slot_vld_o = q.vld;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        assign slot_idx_o[i*IDX_W +: IDX_W]           = q.sidx[i];
        assign slot_x_o[i*XPOS_W +: XPOS_W]           = q.slot[i].xpos;
        assign slot_addr_o[i*ROWADDR_W +: ROWADDR_W]  = q.slot[i].addr;
        assign slot_color_o[i*COLOR_W +: COLOR_W]     = q.slot[i].color;
    end
endmodule

// File: rtl/sprite_line_eval_chk.sv
module sprite_line_eval_chk #(
    parameter int NUM_SPR = 32,
    parameter int SLOTS   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             done_o,
    input logic             ovf_o,
    input logic [SLOTS-1:0] slot_vld_o
);
    localparam int CW = $clog2(NUM_SPR + 2) + 1;
    localparam logic [CW-1:0] LIMIT = CW'(NUM_SPR);

    logic          armed;
    logic [CW-1:0] wait_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            wait_cnt <= '0;
        end else if (start_i) begin
            armed    <= 1'b1;
            wait_cnt <= '0;
        end else if (done_o) begin
            armed    <= 1'b0;
        end else if (armed && wait_cnt != '1) begin
            wait_cnt <= wait_cnt + CW'(1);
        end
    end

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11
    done_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> wait_cnt <= LIMIT);

    // R8
    slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((slot_vld_o & (slot_vld_o + SLOTS'(1))) == '0));

    // R9
    ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ovf_o) |-> (&slot_vld_o));

    // R9
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!ovf_o && slot_vld_o == '0));
endmodule

bind sprite_line_eval sprite_line_eval_chk #(.NUM_SPR(NUM_SPR), .SLOTS(SLOTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .done_o     (done_o),
    .ovf_o      (ovf_o),
    .slot_vld_o (slot_vld_o)
);

// File: tb/sprite_line_eval_tb.sv
`timescale 1ns/1ps
module sprite_line_eval_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [6:0]  wr_addr_i = '0;
    logic [7:0]  wr_data_i = '0;
    logic [7:0]  line_i = '0;
    logic        start_i = 1'b0;
    logic        big_i = 1'b0;
    logic        mag_i = 1'b0;
    logic        done_o;
    logic [3:0]  slot_vld_o;
    logic [19:0] slot_idx_o;
    logic [35:0] slot_x_o;
    logic [43:0] slot_addr_o;
    logic [15:0] slot_color_o;
    logic        ovf_o;
    logic [4:0]  fifth_o;

    always #2.5 clk = ~clk;

    sprite_line_eval u_dut (.*);

    typedef struct {
        logic [3:0]  vld;
        logic [19:0] idx;
        logic [35:0] x;
        logic [43:0] addr;
        logic [15:0] col;
        logic        ovf;
        logic [4:0]  fifth;
        string       tag;
    } exp_t;

    exp_t       sb[$];
    logic [7:0] img [128];
    int         n_chk = 0;
    int         n_fail = 0;
    int         since_start = 0;
    bit         expect_low = 0;
    bit         finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [7:0] line, input logic big, input logic mag);
        exp_t e;
        int   cnt = 0;
        e.vld = '0; e.idx = '0; e.x = '0; e.addr = '0; e.col = '0;
        e.ovf = 1'b0; e.fifth = 5'd31; e.tag = "";
        for (int i = 0; i < 32; i++) begin
            logic [7:0] y, x, p, a, df;
            logic [3:0] row;
            int h;
            y = img[4*i]; x = img[4*i+1]; p = img[4*i+2]; a = img[4*i+3];
            if (y == 8'hD0) begin e.fifth = 5'(i); break; end
            df = line - y - 8'd1;
            h  = (big ? 16 : 8) * (mag ? 2 : 1);
            if (int'(df) < h) begin
                if (cnt == 4) begin e.ovf = 1'b1; e.fifth = 5'(i); break; end
                row = mag ? df[4:1] : df[3:0];
                e.vld[cnt] = 1'b1;
                e.idx[cnt*5 +: 5]   = 5'(i);
                e.x[cnt*9 +: 9]     = a[7] ? ({1'b0, x} - 9'd32) : {1'b0, x};
                e.addr[cnt*11 +: 11] = big ? {p[7:2], 1'b0, row} : {p, row[2:0]};
                e.col[cnt*4 +: 4]   = a[3:0];
                cnt++;
            end
        end
        return e;
    endfunction

    task automatic put(input int n, input logic [7:0] y, x, p, a);
        logic [7:0] b [4];
        b[0] = y; b[1] = x; b[2] = p; b[3] = a;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            wr_en_i = 1'b1; wr_addr_i = 7'(4*n + k); wr_data_i = b[k];
            img[4*n + k] = b[k];
        end
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic fill(input logic [7:0] y);
        for (int n = 0; n < 32; n++) put(n, y, 8'h00, 8'h00, 8'h00);
    endtask

    // driver: pushes the expected result, then launches the walk
    task automatic run_line(input logic [7:0] line, input logic big, input logic mag,
                            input string tag);
        exp_t e;
        e = model(line, big, mag);
        e.tag = tag;
        @(negedge clk);
        line_i = line; big_i = big; mag_i = mag; start_i = 1'b1;
        sb.push_back(e);
        @(negedge clk);
        start_i = 1'b0;
        while (sb.size() != 0 || expect_low) @(negedge clk);
    endtask

    always @(posedge clk) begin
        if (start_i) since_start <= 0;
        else         since_start <= since_start + 1;
    end

    // monitor: pops and compares on each done pulse
    always @(negedge clk) begin
        if (expect_low) begin
            check(done_o == 1'b0, "R11", "done pulse width", 64'(done_o), 64'd0);
            expect_low <= 0;
        end
        if (rst_n && done_o) begin
            if (sb.size() == 0) begin
                check(1'b0, "R11", "unexpected done", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(since_start >= 1 && since_start <= 32, "R11", {e.tag, " done latency"},
                      64'(since_start), 64'd32);
                check(slot_vld_o == e.vld, "R8", {e.tag, " valid"}, 64'(slot_vld_o), 64'(e.vld));
                check(slot_idx_o == e.idx, "R2", {e.tag, " index"}, 64'(slot_idx_o), 64'(e.idx));
                check(slot_x_o == e.x, "R5", {e.tag, " x"}, 64'(slot_x_o), 64'(e.x));
                check(slot_addr_o == e.addr, "R6", {e.tag, " row addr"}, 64'(slot_addr_o), 64'(e.addr));
                check(slot_color_o == e.col, "R7", {e.tag, " colour"}, 64'(slot_color_o), 64'(e.col));
                check(ovf_o == e.ovf, "R9", {e.tag, " overflow"}, 64'(ovf_o), 64'(e.ovf));
                check(fifth_o == e.fifth, "R10", {e.tag, " fifth index"}, 64'(fifth_o), 64'(e.fifth));
                expect_low <= 1;
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #900000;
        check(1'b0, "R11", "watchdog expired", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(done_o == 0, "R1", "done", 64'(done_o), 0);
        check(slot_vld_o == 0, "R1", "valid", 64'(slot_vld_o), 0);
        check(ovf_o == 0, "R1", "overflow", 64'(ovf_o), 0);
        check(fifth_o == 0, "R1", "fifth", 64'(fifth_o), 0);
        rst_n = 1'b1;

        // R4: terminator in entry 0 hides everything
        fill(8'hD0);
        run_line(8'd10, 0, 0, "R4 empty");

        // R2 R5 R6 R7: basic 8x8 table, terminator at entry 3 hides entry 4
        put(0, 8'hFF, 8'h10, 8'h21, 8'h85);
        put(1, 8'h03, 8'h80, 8'h40, 8'h0C);
        put(2, 8'h05, 8'h00, 8'h07, 8'h83);
        put(3, 8'hD0, 8'h00, 8'h00, 8'h00);
        put(4, 8'h00, 8'h44, 8'h55, 8'h06);
        run_line(8'd0, 0, 0, "R2 top line");
        run_line(8'd5, 0, 0, "R2 line5");
        run_line(8'd8, 0, 0, "R2 line8 edge");
        run_line(8'd9, 0, 0, "R4 line9");
        // R6: 16x16 quadrant row addressing
        run_line(8'd12, 1, 0, "R6 big line12");
        run_line(8'd15, 1, 0, "R6 big line15");
        run_line(8'd16, 1, 0, "R6 big line16");
        // R3: magnified heights and halved row
        run_line(8'd13, 0, 1, "R3 mag line13");
        run_line(8'd20, 1, 1, "R3 mag big line20");
        run_line(8'd31, 1, 1, "R3 mag big line31");

        // R9: overflow at the fifth hit with later hits after it
        fill(8'h60);
        put(0, 8'h0F, 8'h01, 8'h10, 8'h01);
        put(1, 8'h40, 8'h02, 8'h11, 8'h02);
        put(2, 8'h0E, 8'h03, 8'h12, 8'h83);
        put(3, 8'h10, 8'h04, 8'h13, 8'h04);
        put(4, 8'h0C, 8'h05, 8'h14, 8'h05);
        put(5, 8'h0F, 8'h06, 8'h15, 8'h06);
        put(6, 8'h0F, 8'h07, 8'h16, 8'h07);
        put(7, 8'h0F, 8'h08, 8'h17, 8'h08);
        put(8, 8'hD0, 8'h00, 8'h00, 8'h00);
        run_line(8'h12, 0, 0, "R9 overflow");
        run_line(8'h30, 0, 0, "R9 cleared");

        // R10: full table without terminator, entry 31 covers the line
        fill(8'h20);
        put(29, 8'h8F, 8'h30, 8'h31, 8'h09);
        put(31, 8'h8F, 8'h1F, 8'h32, 8'h8A);
        run_line(8'h90, 0, 0, "R10 full walk");
        put(30, 8'h8F, 8'h00, 8'h33, 8'h0B);
        put(28, 8'h8F, 8'h00, 8'h34, 8'h0C);
        put(27, 8'h8F, 8'h00, 8'h35, 8'h0D);
        run_line(8'h90, 0, 0, "R9 last entry overflow");

        finish_run();
    end
endmodule